// File: doc/BRIEF.md
# Nonvolatile Command Sequence Detector

This block watches the read traffic of an asynchronous SRAM-style port and recognises a fixed unlock sequence of six read addresses. The last address in the sequence picks one of two nonvolatile operations. One is a store, which copies the SRAM contents into the nonvolatile array. The other is a recall, which copies the array back into the SRAM. The block raises a one-clock command pulse for the chosen operation. It also controls the data-output enable, so that the read that completes a command leaves the data bus in high impedance.

The chip enable and write enable come from the asynchronous bus. The block samples each bus cycle on the falling edge of chip enable, after passing that edge through a two-flop synchroniser on the system clock. It captures the address at that point. A busy input from the nonvolatile engine keeps the matcher idle while an operation runs, so that no further sequence can be collected.

Top module: `nv_seq_detect`

## Requirements
- R1: While rst_n is low, and after it rises, store_pulse, recall_pulse and dout_en are 0 and the sequence position is idle.
- R2: A bus cycle is taken when ce_n falls. Its command pulse and its dout_en value appear in the clock cycle that starts at the third rising clock edge, counting the first edge that samples ce_n low. addr and we_n are sampled in the cycle before that edge.
- R3: Six consecutive cycles with we_n high and addresses 0x0000, 0x1555, 0x0AAA, 0x1FFF, 0x10F0, 0x0F0F produce exactly one store_pulse, one clock wide. The sequence position then returns to idle.
- R4: The same first five addresses followed by 0x0F0E produce exactly one recall_pulse, one clock wide, and no store_pulse.
- R5: A cycle taken with we_n low returns the matcher to idle, whatever its address, and produces no pulse.
- R6: A cycle whose address is not the next expected one returns the matcher to idle. If that address is 0x0000, it counts as the first step of a new sequence.
- R7: During a read cycle (ce_n low, we_n high), dout_en is 1 from the time given in R2 until ce_n is released. On the cycle that completes a command it stays 0. It is 0 whenever the synchronised ce_n is high or we_n is low.
- R8: While busy is high, no pulse is produced and the matcher is held idle. A sequence that was partly collected must then start again from 0x0000.
- R9: store_pulse and recall_pulse are never high together, and neither is high for two clock cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Bus chip enable, active low, asynchronous |
| we_n | input | 1 | Bus write enable, active low |
| addr | input | 13 | Bus address |
| busy | input | 1 | Nonvolatile operation in progress |
| store_pulse | output | 1 | One-clock request to copy SRAM into the nonvolatile array |
| recall_pulse | output | 1 | One-clock request to copy the nonvolatile array into SRAM |
| dout_en | output | 1 | Data output drive enable; 0 keeps the bus in high impedance |

## Verification
Two functions can meet on one bus cycle. A command can complete on the sixth cycle at the same moment that busy locks the matcher. A mismatch can reset the matcher at the same moment that the same address, 0x0000, restarts it. The bench provokes the first case by raising busy on exactly the sixth read of a valid sequence. It then expects no pulse and a normally driven read. It provokes the second case by breaking sequences with 0x0000 and then finishing them, and it expects a command. Randomly chosen cycles draw the next expected address most of the time, with write and busy faults mixed in. A reference model in the bench judges every one of these cycles.

// File: rtl/nv_seq_detect.sv
module nv_seq_detect #(
  parameter int ADDR_W = 13,
  parameter logic [ADDR_W-1:0] K0 = 13'h0000,
  parameter logic [ADDR_W-1:0] K1 = 13'h1555,
  parameter logic [ADDR_W-1:0] K2 = 13'h0AAA,
  parameter logic [ADDR_W-1:0] K3 = 13'h1FFF,
  parameter logic [ADDR_W-1:0] K4 = 13'h10F0,
  parameter logic [ADDR_W-1:0] STORE_ADDR  = 13'h0F0F,
  parameter logic [ADDR_W-1:0] RECALL_ADDR = 13'h0F0E
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              busy,
  output logic              store_pulse,
  output logic              recall_pulse,
  output logic              dout_en
);

  localparam int LAST   = 5;
  localparam int STEP_W = $clog2(LAST + 1);
  localparam logic [STEP_W-1:0] LAST_S = STEP_W'(LAST);

  logic              ce_s1, ce_s2, ce_s3;
  logic              ce_fall;
  logic [STEP_W-1:0] step;
  logic [ADDR_W-1:0] want;
  logic              at_last, is_store, is_recall, hit, take;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) {ce_s1, ce_s2, ce_s3} <= 3'b111;
    else        {ce_s1, ce_s2, ce_s3} <= {ce_n, ce_s1, ce_s2};

  assign ce_fall = ce_s3 & ~ce_s2;
  assign take    = ce_fall & ~busy & we_n;

  always_comb
    case (step)
      STEP_W'(0): want = K0;
      STEP_W'(1): want = K1;
      STEP_W'(2): want = K2;
      STEP_W'(3): want = K3;
      default:    want = K4;
    endcase

  assign at_last   = (step == LAST_S);
  assign is_store  = at_last & (addr == STORE_ADDR);
  assign is_recall = at_last & (addr == RECALL_ADDR);
  assign hit       = is_store | is_recall;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                       step <= '0;
    else if (busy)                    step <= '0;
    else if (ce_fall) begin
      if (!we_n)                      step <= '0;
      else if (!at_last && addr == want) step <= step + STEP_W'(1);
      else if (hit)                   step <= '0;
      else                            step <= (addr == K0) ? STEP_W'(1) : '0;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      store_pulse  <= 1'b0;
      recall_pulse <= 1'b0;
    end else begin
      store_pulse  <= take & is_store;
      recall_pulse <= take & is_recall;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                dout_en <= 1'b0;
    else if (ce_s2 || !we_n)   dout_en <= 1'b0;
    else if (ce_fall)          dout_en <= ~(hit & ~busy);

  // R9
  one_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(store_pulse && recall_pulse));

  // R9
  store_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    store_pulse |=> !store_pulse);

  // R9
  recall_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    recall_pulse |=> !recall_pulse);

  // R7
  hiz_on_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (store_pulse || recall_pulse) |-> !dout_en);

  // R8
  busy_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (step == '0 && !store_pulse && !recall_pulse));

  // R5
  write_break_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_fall && !we_n) |=> (step == '0 && !store_pulse && !recall_pulse));

  // R2
  edge_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (store_pulse || recall_pulse) |-> $past(ce_fall));

endmodule

// File: tb/test_nv_seq_detect.sv
`timescale 1ns/1ps
module test_nv_seq_detect;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ce_n = 1'b1, we_n = 1'b1, busy = 1'b0;
  logic [12:0] addr = '0;
  logic        store_pulse, recall_pulse, dout_en;

  int tests = 0, fails = 0;
  int mstep = 0;

  always #5 clk = ~clk;

  nv_seq_detect i_nv_seq_detect (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .addr(addr),
    .busy(busy), .store_pulse(store_pulse), .recall_pulse(recall_pulse),
    .dout_en(dout_en));

  function automatic logic [12:0] seq_addr(int i);
    case (i)
      0: return 13'h0000;
      1: return 13'h1555;
      2: return 13'h0AAA;
      3: return 13'h1FFF;
      default: return 13'h10F0;
    endcase
  endfunction

  task automatic check(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // reference model: returns 1=store 2=recall 0=none, updates mstep, gives dout
  function automatic int model(logic [12:0] a, bit w, bit b, output bit d);
    int r = 0;
    if (b) begin mstep = 0; d = w; end
    else if (!w) begin mstep = 0; d = 0; end
    else if (mstep < 5 && a == seq_addr(mstep)) begin mstep++; d = 1; end
    else if (mstep == 5 && a == 13'h0F0F) begin r = 1; mstep = 0; d = 0; end
    else if (mstep == 5 && a == 13'h0F0E) begin r = 2; mstep = 0; d = 0; end
    else begin mstep = (a == 13'h0000) ? 1 : 0; d = 1; end
    return r;
  endfunction

  task automatic do_cycle(logic [12:0] a, bit w, bit b, string req);
    int  sc = 0, rc = 0, sidx = 0, ridx = 0, both = 0, exp;
    bit  ed;
    exp = model(a, w, b, ed);
    @(negedge clk);
    addr = a; we_n = w; busy = b; ce_n = 1'b0;
    for (int i = 1; i <= 5; i++) begin
      @(negedge clk);
      if (store_pulse)  begin sc++; sidx = i; end
      if (recall_pulse) begin rc++; ridx = i; end
      if (store_pulse && recall_pulse) both++;
    end
    check({req, " R9 no overlap"}, both, 0);
    check({req, " R3 store count"}, sc, exp == 1 ? 1 : 0);
    check({req, " R4 recall count"}, rc, exp == 2 ? 1 : 0);
    if (exp == 1) check({req, " R2 store latency"}, sidx, 3);
    if (exp == 2) check({req, " R2 recall latency"}, ridx, 3);
    check({req, " R7 dout_en in cycle"}, int'(dout_en), int'(ed));
    ce_n = 1'b1; we_n = 1'b1;
    sc = 0; rc = 0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      if (store_pulse) sc++;
      if (recall_pulse) rc++;
    end
    check({req, " R9 quiet after cycle"}, sc + rc, 0);
    check({req, " R7 dout_en released"}, int'(dout_en), 0);
    busy = 1'b0;
  endtask

  task automatic run_seq(logic [12:0] last, string req);
    for (int i = 0; i < 5; i++) do_cycle(seq_addr(i), 1'b1, 1'b0, req);
    do_cycle(last, 1'b1, 1'b0, req);
  endtask

  initial begin
    #2_000_000;
    fails++; tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R1 store in reset", int'(store_pulse), 0);
    check("R1 recall in reset", int'(recall_pulse), 0);
    check("R1 dout_en in reset", int'(dout_en), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 dout_en after reset", int'(dout_en), 0);

    run_seq(13'h0F0F, "R3 store seq");
    run_seq(13'h0F0E, "R4 recall seq");
    // write low mid-sequence breaks it
    for (int i = 0; i < 3; i++) do_cycle(seq_addr(i), 1'b1, 1'b0, "R5 pre");
    do_cycle(seq_addr(3), 1'b0, 1'b0, "R5 write break");
    do_cycle(seq_addr(4), 1'b1, 1'b0, "R5 after");
    do_cycle(13'h0F0F, 1'b1, 1'b0, "R5 no store");
    // mismatch of 0x0000 restarts
    do_cycle(13'h0000, 1'b1, 1'b0, "R6 a");
    do_cycle(13'h1555, 1'b1, 1'b0, "R6 b");
    do_cycle(13'h0000, 1'b1, 1'b0, "R6 restart");
    for (int i = 1; i < 5; i++) do_cycle(seq_addr(i), 1'b1, 1'b0, "R6 rest");
    do_cycle(13'h0F0F, 1'b1, 1'b0, "R6 store after restart");
    // wrong sixth address
    for (int i = 0; i < 5; i++) do_cycle(seq_addr(i), 1'b1, 1'b0, "R6 pre");
    do_cycle(13'h0F0D, 1'b1, 1'b0, "R6 bad last");
    do_cycle(13'h0F0E, 1'b1, 1'b0, "R6 late recall");
    // busy on completing cycle
    for (int i = 0; i < 5; i++) do_cycle(seq_addr(i), 1'b1, 1'b0, "R8 pre");
    do_cycle(13'h0F0F, 1'b1, 1'b1, "R8 busy on sixth");
    // busy mid-sequence forces restart
    for (int i = 0; i < 2; i++) do_cycle(seq_addr(i), 1'b1, 1'b0, "R8 pre2");
    do_cycle(13'h0000, 1'b1, 1'b1, "R8 busy mid");
    for (int i = 2; i < 5; i++) do_cycle(seq_addr(i), 1'b1, 1'b0, "R8 cont");
    do_cycle(13'h0F0E, 1'b1, 1'b0, "R8 no recall");

    for (int n = 0; n < 400; n++) begin
      logic [12:0] a;
      int p = $urandom_range(99);
      bit w = ($urandom_range(99) >= 5);
      bit b = ($urandom_range(99) < 5);
      if (p < 65) a = (mstep < 5) ? seq_addr(mstep)
                                   : (($urandom_range(1) == 0) ? 13'h0F0F : 13'h0F0E);
      else if (p < 85) a = ($urandom_range(1) == 0) ? 13'h0000 : 13'h0F0E;
      else a = 13'($urandom);
      do_cycle(a, w, b, "R2 random");
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule